// File: doc/BRIEF.md
# Relocation-Aware Victim Way Selector

This block serves one bank of a shared last-level cache that never forces blocks out of the cores' private caches. When a fill needs room in a set, the block picks the way to replace. A way is eligible only if it is empty, or if no core holds a private copy of its block. Among the eligible ways it prefers an empty way, then a block predicted dead, then any other block, and within a class it takes the way closest to the least-recently-used end.

The same lookup also qualifies a tag hit. A block that was moved into this set from another set is kept there on behalf of its home set. It is flagged relocated and never counts as a hit for the set it now occupies.

The caller presents the per-way state of one set, a lookup tag and a request strobe. The victim choice and the hit result come back together one cycle later.

Top module: `relocVictimSel`

## Requirements
- R1: If any way has its valid flag at 0, the victim is an invalid way, specifically the lowest-numbered one, and the found flag is 1.
- R2: If every way is valid, the victim is chosen among ways whose dead flag is 1 and whose private flag is 0. The pick is the one with the largest age (age is 4 bits per way, 15 = least recently used), and an equal age goes to the lower way index.
- R3: If every way is valid and no way is both dead and free of private copies, the victim is the way with private flag 0 that has the largest age, and an equal age goes to the lower way index.
- R4: A valid way whose private flag is 1 is never reported as victim. When no way qualifies (all ways valid with private flag 1), the found flag is 0 and the victim way field is 0.
- R5: The hit flag is 1 only when some way is valid, has its relocated flag at 0 and has a stored tag equal to the lookup tag. The hit way is the lowest-numbered such way, and when there is none the hit flag and the hit way are 0.
- R6: A way with its relocated flag at 1 never produces a hit, even with a matching tag, and the relocated flag has no effect on victim eligibility.
- R7: Results for a request sampled at a rising edge with reqValid at 1 appear after that edge with respValid at 1. In a cycle without a request, respValid is 0 and the four result outputs keep their previous values.
- R8: While reset (rstN at 0) is applied, and after it until the first request, respValid, victimFound, victimWay, hitFound and hitWay are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe; set state and lookup tag are sampled with it |
| wayValid | input | NUM_WAYS | Valid flag per way |
| wayReloc | input | NUM_WAYS | Relocated flag per way |
| wayDead | input | NUM_WAYS | Predicted-dead flag per way |
| wayPriv | input | NUM_WAYS | Private-copy-present flag per way |
| wayAge | input | NUM_WAYS*AGE_W | Age per way, way i in bits [i*AGE_W +: AGE_W], maximum value = LRU |
| wayTags | input | NUM_WAYS*TAG_W | Stored tag per way, way i in bits [i*TAG_W +: TAG_W] |
| lookupTag | input | TAG_W | Tag to compare |
| respValid | output | 1 | Result of the previous cycle's request is on the outputs |
| victimFound | output | 1 | An eligible victim exists |
| victimWay | output | $clog2(NUM_WAYS) | Chosen victim way |
| hitFound | output | 1 | A qualified hit exists |
| hitWay | output | $clog2(NUM_WAYS) | Hitting way |

## Verification
The clocked properties look back one edge at the set state presented with the request. They therefore assume that every per-way flag, age and tag is a known value and is held steady across the edge where reqValid is sampled. The bench changes inputs only on falling edges and keeps them fixed through the following rising edge. The sweep draws the valid flags so that full sets dominate, which keeps the dead-class and plain-class orderings in play. It draws tags from a four-value pool so that matching, relocated and multiple hits occur often.

// File: rtl/relocVictimPkg.sv
package relocVictimPkg;

  // Victim classes in priority order; index 0 wins over 1, 1 over 2.
  localparam int NUM_CLASSES = 3;
  localparam int CLS_EMPTY   = 0;
  localparam int CLS_DEAD    = 1;
  localparam int CLS_PLAIN   = 2;

  // Strobes from control to datapath.
  typedef struct packed {
    logic captureEn;   // load result registers this edge
    logic holdEn;      // keep result registers (no request)
  } ctrlStrobeT;

endpackage

// File: rtl/relocAgePick.sv
// Picks the candidate with the largest age; equal ages resolve to lower index.
module relocAgePick #(
  parameter int NUM_WAYS = 16,
  parameter int AGE_W    = 4,
  localparam int IDX_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0]       candVec,
  input  logic [NUM_WAYS*AGE_W-1:0] ageFlat,
  output logic                      pickFound,
  output logic [IDX_W-1:0]          pickWay
);

  logic [AGE_W-1:0] bestAge;

  always_comb begin
    pickFound = 1'b0;
    pickWay   = '0;
    bestAge   = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (candVec[i] && (!pickFound || (ageFlat[i*AGE_W +: AGE_W] > bestAge))) begin
        pickFound = 1'b1;
        pickWay   = IDX_W'(i);
        bestAge   = ageFlat[i*AGE_W +: AGE_W];
      end
    end
  end

endmodule

// File: rtl/relocHitDetect.sv
// Hit qualification: valid, not relocated, tag equal; lowest index wins.
module relocHitDetect #(
  parameter int NUM_WAYS = 16,
  parameter int TAG_W    = 20,
  localparam int IDX_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0]       wayValid,
  input  logic [NUM_WAYS-1:0]       wayReloc,
  input  logic [NUM_WAYS*TAG_W-1:0] wayTags,
  input  logic [TAG_W-1:0]          lookupTag,
  output logic                      hitAny,
  output logic [IDX_W-1:0]          hitIdx
);

  logic [NUM_WAYS-1:0] tagEq;
  logic [NUM_WAYS-1:0] hitVec;

  for (genvar g = 0; g < NUM_WAYS; g++) begin : gCmp
    assign tagEq[g] = (wayTags[g*TAG_W +: TAG_W] == lookupTag);
  end

  assign hitVec = wayValid & ~wayReloc & tagEq;

  always_comb begin
    hitAny = 1'b0;
    hitIdx = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        hitAny = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/relocVictimCtrl.sv
module relocVictimCtrl
  import relocVictimPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output ctrlStrobeT ctl,
  output logic       respValid
);

  always_comb begin
    ctl.captureEn = reqValid;
    ctl.holdEn    = !reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) respValid <= 1'b0;
    else       respValid <= reqValid;
  end

  AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid); // R7
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid); // R7

endmodule

// File: rtl/relocVictimDatapath.sv
module relocVictimDatapath
  import relocVictimPkg::*;
#(
  parameter int NUM_WAYS = 16,
  parameter int AGE_W    = 4,
  parameter int TAG_W    = 20,
  localparam int IDX_W   = $clog2(NUM_WAYS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobeT                ctl,
  input  logic [NUM_WAYS-1:0]       wayValid,
  input  logic [NUM_WAYS-1:0]       wayReloc,
  input  logic [NUM_WAYS-1:0]       wayDead,
  input  logic [NUM_WAYS-1:0]       wayPriv,
  input  logic [NUM_WAYS*AGE_W-1:0] wayAge,
  input  logic [NUM_WAYS*TAG_W-1:0] wayTags,
  input  logic [TAG_W-1:0]          lookupTag,
  output logic                      victimFound,
  output logic [IDX_W-1:0]          victimWay,
  output logic                      hitFound,
  output logic [IDX_W-1:0]          hitWay
);

  localparam logic [NUM_WAYS-1:0] LSB_ONE = NUM_WAYS'(1);

  logic [NUM_WAYS-1:0]       classCand [NUM_CLASSES];
  logic [NUM_WAYS*AGE_W-1:0] classAge  [NUM_CLASSES];
  logic [NUM_CLASSES-1:0]    classFound;
  logic [IDX_W-1:0]          classWay  [NUM_CLASSES];

  logic             nxtFound;
  logic [IDX_W-1:0] nxtWay;
  logic             nxtHit;
  logic [IDX_W-1:0] nxtHitWay;

  // Class membership. Empty ways ignore age so the lowest index wins.
  always_comb begin
    classCand[CLS_EMPTY] = ~wayValid;
    classCand[CLS_DEAD]  = wayValid & wayDead & ~wayPriv;
    classCand[CLS_PLAIN] = wayValid & ~wayPriv;
    classAge[CLS_EMPTY]  = '0;
    classAge[CLS_DEAD]   = wayAge;
    classAge[CLS_PLAIN]  = wayAge;
  end

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : gClass
    relocAgePick #(
      .NUM_WAYS(NUM_WAYS),
      .AGE_W   (AGE_W)
    ) u_pick (
      .candVec  (classCand[c]),
      .ageFlat  (classAge[c]),
      .pickFound(classFound[c]),
      .pickWay  (classWay[c])
    );
  end

  // Priority across classes.
  always_comb begin
    nxtFound = 1'b0;
    nxtWay   = '0;
    for (int c = NUM_CLASSES - 1; c >= 0; c--) begin
      if (classFound[c]) begin
        nxtFound = 1'b1;
        nxtWay   = classWay[c];
      end
    end
  end

  relocHitDetect #(
    .NUM_WAYS(NUM_WAYS),
    .TAG_W   (TAG_W)
  ) u_hit (
    .wayValid (wayValid),
    .wayReloc (wayReloc),
    .wayTags  (wayTags),
    .lookupTag(lookupTag),
    .hitAny   (nxtHit),
    .hitIdx   (nxtHitWay)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimFound <= 1'b0;
      victimWay   <= '0;
      hitFound    <= 1'b0;
      hitWay      <= '0;
    end else if (ctl.captureEn) begin
      victimFound <= nxtFound;
      victimWay   <= nxtWay;
      hitFound    <= nxtHit;
      hitWay      <= nxtHitWay;
    end
  end

  AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.captureEn) && $past(rstN) && ($past(wayValid) != '1))
      |-> (victimFound && ((($past(wayValid) >> victimWay) & LSB_ONE) == '0))); // R1
  AST_DEAD_BEFORE_PLAIN: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.captureEn) && $past(rstN) && ($past(wayValid) == '1)
      && ($past(wayDead & ~wayPriv) != '0))
      |-> (victimFound && ((($past(wayDead & ~wayPriv) >> victimWay) & LSB_ONE) != '0))); // R2
  AST_NO_PRIV_VICTIM: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.captureEn) && $past(rstN) && victimFound)
      |-> ((($past(wayValid & wayPriv) >> victimWay) & LSB_ONE) == '0)); // R4
  AST_NOT_FOUND_ONLY_IF_ALL_PRIV: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.captureEn) && $past(rstN) && !victimFound)
      |-> ($past(wayValid & wayPriv) == '1)); // R4
  AST_HIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.captureEn) && $past(rstN) && hitFound)
      |-> ((($past(wayValid & ~wayReloc) >> hitWay) & LSB_ONE) != '0)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.holdEn) && $past(rstN))
      |-> ($stable(victimFound) && $stable(victimWay) && $stable(hitFound) && $stable(hitWay))); // R7

endmodule

// File: rtl/relocVictimSel.sv
module relocVictimSel
  import relocVictimPkg::*;
#(
  parameter int NUM_WAYS = 16,
  parameter int AGE_W    = 4,
  parameter int TAG_W    = 20,
  localparam int IDX_W   = $clog2(NUM_WAYS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic [NUM_WAYS-1:0]       wayValid,
  input  logic [NUM_WAYS-1:0]       wayReloc,
  input  logic [NUM_WAYS-1:0]       wayDead,
  input  logic [NUM_WAYS-1:0]       wayPriv,
  input  logic [NUM_WAYS*AGE_W-1:0] wayAge,
  input  logic [NUM_WAYS*TAG_W-1:0] wayTags,
  input  logic [TAG_W-1:0]          lookupTag,
  output logic                      respValid,
  output logic                      victimFound,
  output logic [IDX_W-1:0]          victimWay,
  output logic                      hitFound,
  output logic [IDX_W-1:0]          hitWay
);

  ctrlStrobeT ctl;

  relocVictimCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .ctl      (ctl),
    .respValid(respValid)
  );

  relocVictimDatapath #(
    .NUM_WAYS(NUM_WAYS),
    .AGE_W   (AGE_W),
    .TAG_W   (TAG_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .wayValid   (wayValid),
    .wayReloc   (wayReloc),
    .wayDead    (wayDead),
    .wayPriv    (wayPriv),
    .wayAge     (wayAge),
    .wayTags    (wayTags),
    .lookupTag  (lookupTag),
    .victimFound(victimFound),
    .victimWay  (victimWay),
    .hitFound   (hitFound),
    .hitWay     (hitWay)
  );

endmodule

// File: tb/relocVictimSel_tb.sv
module relocVictimSel_tb;

  localparam int NW = 16;
  localparam int AW = 4;
  localparam int TW = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [NW-1:0] tV = '0, tR = '0, tD = '0, tP = '0;
  logic [AW-1:0] tAge [NW];
  logic [TW-1:0] tTag [NW];
  logic [TW-1:0] tLook = '0;
  logic [NW*AW-1:0] ageFlat;
  logic [NW*TW-1:0] tagFlat;

  logic respValid, victimFound, hitFound;
  logic [3:0] victimWay, hitWay;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  for (genvar g = 0; g < NW; g++) begin : gPack
    assign ageFlat[g*AW +: AW] = tAge[g];
    assign tagFlat[g*TW +: TW] = tTag[g];
  end

  relocVictimSel u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .wayValid(tV), .wayReloc(tR), .wayDead(tD), .wayPriv(tP),
    .wayAge(ageFlat), .wayTags(tagFlat), .lookupTag(tLook),
    .respValid(respValid), .victimFound(victimFound), .victimWay(victimWay),
    .hitFound(hitFound), .hitWay(hitWay)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference: class scan by age descending, then index ascending.
  function automatic void model(output logic ef, output int ew, output logic hf,
                                output int hw, output string cls);
    ef = 1'b0; ew = 0; hf = 1'b0; hw = 0; cls = "R4";
    for (int i = 0; i < NW; i++)
      if (!ef && !tV[i]) begin ef = 1'b1; ew = i; cls = "R1"; end
    for (int pass = 0; pass < 2; pass++)
      for (int a = 15; a >= 0; a--)
        for (int i = 0; i < NW; i++)
          if (!ef && tV[i] && !tP[i] && (pass == 1 || tD[i]) && int'(tAge[i]) == a) begin
            ef = 1'b1; ew = i; cls = (pass == 0) ? "R2" : "R3";
          end
    for (int i = NW - 1; i >= 0; i--)
      if (tV[i] && !tR[i] && tTag[i] == tLook) begin hf = 1'b1; hw = i; end
  endfunction

  task automatic runOne(input string hitReq);
    logic ef, hf; int ew, hw; string cls;
    model(ef, ew, hf, hw, cls);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check("R7", "respValid", int'(respValid), 1);
    check(cls, "victimFound", int'(victimFound), int'(ef));
    check(cls, "victimWay", int'(victimWay), ew);
    check(hitReq, "hitFound", int'(hitFound), int'(hf));
    check(hitReq, "hitWay", int'(hitWay), hw);
  endtask

  task automatic clearSet();
    tV = '1; tR = '0; tD = '0; tP = '1; tLook = 20'hABCDE;
    for (int i = 0; i < NW; i++) begin tAge[i] = 4'(i); tTag[i] = 20'(i); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] keepV;
    logic keepF;
    clearSet();
    repeat (3) @(negedge clk);
    check("R8", "respValid in reset", int'(respValid), 0);
    check("R8", "victimFound in reset", int'(victimFound), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8", "victimWay after reset", int'(victimWay), 0);
    check("R8", "hitFound after reset", int'(hitFound), 0);
    check("R8", "hitWay after reset", int'(hitWay), 0);

    // R1: all invalid, then two invalid ways
    clearSet(); tV = '0; runOne("R5");
    clearSet(); tV[9] = 1'b0; tV[3] = 1'b0; tP = '0; runOne("R5");
    // R4: every way privately held
    clearSet(); runOne("R5");
    // R3: tie on age between ways 5 and 6
    clearSet(); tP[5] = 1'b0; tP[6] = 1'b0; tAge[5] = 4'd10; tAge[6] = 4'd10; runOne("R5");
    // R2: dead way beats an older plain way; R4: dead but private ignored
    clearSet(); tP[2] = 1'b0; tD[2] = 1'b1; tAge[2] = 4'd3;
    tP[8] = 1'b0; tAge[8] = 4'd15; tD[12] = 1'b1; runOne("R5");
    // R6: relocated matching way gives no hit, and stays eligible as victim
    clearSet(); tLook = 20'h4; tR[4] = 1'b1; tP[4] = 1'b0; runOne("R6");
    // R5: lowest of two qualified hits past a relocated one
    clearSet(); tTag[4] = 20'h77; tTag[11] = 20'h77; tTag[13] = 20'h77;
    tR[4] = 1'b1; tLook = 20'h77; runOne("R5");

    // R7: idle cycle holds results
    keepV = victimWay; keepF = victimFound;
    clearSet(); tV = '0;
    @(negedge clk);
    check("R7", "respValid idle", int'(respValid), 0);
    check("R7", "victimWay held", int'(victimWay), int'(keepV));
    check("R7", "victimFound held", int'(victimFound), int'(keepF));

    // Sweep
    for (int t = 0; t < 4000; t++) begin
      for (int i = 0; i < NW; i++) begin
        tV[i] = (t % 3 == 0) ? ($urandom % 16 != 0) : 1'b1;
        tR[i] = ($urandom % 4 == 0);
        tD[i] = ($urandom % 5 == 0);
        tP[i] = ($urandom % 8 != 0) || (t % 11 == 0);
        tAge[i] = 4'($urandom % ((t % 2 == 0) ? 4 : 16));
        tTag[i] = 20'($urandom % 4);
      end
      tLook = 20'($urandom % 4);
      runOne("R5/R6");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule